// File: doc/BRIEF.md
# Self-Timed Sector Erase Engine

This block is the automatic erase engine inside a flash array that is divided into sectors. A command front end, which is a separate block, issues a one-cycle start together with a mask of the sectors to clear. The engine then works through two phases with no further help from the host. First it drives every byte of the chosen sectors to all zeros and confirms each one. After that it applies timed erase pulses and re-reads the sectors until every byte reads all ones.

While the engine runs, the active-low ready line is held low. A read from any address inside a sector being cleared returns a status byte whose top bit is 0. When the work ends, the array returns to normal reads and the erased bytes show all ones.

An abort input models a reset command arriving mid-operation. It stops the engine at once and fills the affected sectors with a non-erased, pseudo-random pattern, so the host has to restart the erase. The array itself is a small register memory with a direct load port, which lets the surrounding test logic seed its contents.

Top module: `efs_erase_engine`

## Requirements
- R1: After reset, busy_n is 1 and erase_fail is 0, and each byte at address a reads 8'hA5 XOR a.
- R2: A start pulse seen while idle latches sector_sel, and busy_n reads 0 from the next cycle. A start pulse that arrives while busy is ignored, so sectors outside the latched mask keep their data.
- R3: The status byte read from a selected sector has bit 2 set to 0 during the zero-fill phase and set to 1 during the erase phase. Once bit 2 is 1 it never returns to 0 within one operation, and both phases appear in every operation.
- R4: When the operation succeeds, busy_n returns to 1, erase_fail stays 0, and every byte of the selected sectors reads 8'hFF. Sector s covers addresses 4s to 4s+3.
- R5: While busy, a read of any address inside a selected sector returns a status byte with bit 7 equal to 0 and bit 3 equal to 1.
- R6: Sectors outside the mask keep their contents, and they return normal data even while the engine is busy.
- R7: An abort while busy drives busy_n to 1 at the next edge. Every byte of the selected sectors is then left with bit 7 equal to 0, so it does not read as erased. Other sectors are untouched. An abort while idle has no effect. A later erase of the same sectors completes normally.
- R8: Each erase pulse turns two more low-order bits of a byte to 1. If a selected byte still differs from 8'hFF after MAX_PULSES pulses, the engine stops with erase_fail set to 1 and busy_n set to 1. For example, with MAX_PULSES=3 the byte reads 8'h3F.
- R9: The load port writes ld_data to ld_addr only while the engine is idle. Load requests made while busy are dropped.
- R10: A start with an empty mask finishes by itself and changes no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; sets the engine to idle and the array to its reset pattern |
| start | input | 1 | One-cycle request to begin an erase |
| sector_sel | input | NUM_SECT | Mask of the sectors to erase |
| abort | input | 1 | Stops an operation in progress and leaves its sectors undefined |
| ld_en | input | 1 | Direct write strobe for the array |
| ld_addr | input | ADDR_W | Direct write address |
| ld_data | input | DATA_W | Direct write data |
| rd_addr | input | ADDR_W | Read or poll address |
| rd_data | output | DATA_W | Array data, or the status byte for a sector being erased |
| busy_n | output | 1 | 0 while the engine runs, 1 when it is idle |
| erase_fail | output | 1 | Set when the pulse limit was reached without a full erase |

## Verification
The assertions rely on the front end pulsing start and abort for a single cycle. They also rely on it presenting a stable mask when start is high. The bench drives every input on the falling edge and holds each request for exactly one cycle, so those conditions are met. Loads and second starts that overlap an operation are sent on purpose, because the engine is required to drop them.

// File: rtl/efs_pkg.sv
package efs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_PGM,
        ST_PRE_VFY,
        ST_ERS_PULSE,
        ST_ERS_VFY
    } efs_state_e;
endpackage

// File: rtl/efs_lfsr.sv
module efs_lfsr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] value
);
    logic [W-1:0] lf_d, lf_q;

    always_comb begin
        lf_d = lf_q >> 1;
        if (lf_q[0]) lf_d = lf_d ^ W'(8'hB8);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lf_q <= W'(1);
        else        lf_q <= lf_d;
    end

    assign value = lf_q;
endmodule

// File: rtl/efs_array.sv
module efs_array #(
    parameter int DATA_W     = 8,
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 4,
    parameter int STEP       = 2,
    localparam int DEPTH     = NUM_SECT * SECT_WORDS,
    localparam int ADDR_W    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [DATA_W-1:0] ld_data,
    input  logic              pgm_en,
    input  logic [ADDR_W-1:0] pgm_addr,
    input  logic              pulse_en,
    input  logic              scr_en,
    input  logic [NUM_SECT-1:0] sel,
    input  logic [7:0]        seed,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [ADDR_W-1:0] vf_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] vf_data
);
    localparam logic [DATA_W-1:0] PULSE_ONES = DATA_W'((1 << STEP) - 1);
    localparam logic [DATA_W-1:0] LOW_MASK   = {1'b0, {(DATA_W-1){1'b1}}};

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_d[i] = mem_q[i];
            if (scr_en && sel[i / SECT_WORDS])
                mem_d[i] = (DATA_W'(seed) ^ DATA_W'(i * 59)) & LOW_MASK;
            else if (pulse_en && sel[i / SECT_WORDS])
                mem_d[i] = (mem_q[i] << STEP) | PULSE_ONES;
            if (pgm_en && pgm_addr == ADDR_W'(i)) mem_d[i] = '0;
            if (ld_en && ld_addr == ADDR_W'(i))   mem_d[i] = ld_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= DATA_W'(32'hA5 ^ i);
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rd_data = mem_q[rd_addr];
    assign vf_data = mem_q[vf_addr];

    // R3
    excl_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(pgm_en && pulse_en));
    // R9
    load_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |-> !(pgm_en || pulse_en || scr_en));
endmodule

// File: rtl/efs_ctrl.sv
module efs_ctrl
    import efs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 4,
    parameter int PULSE_CYC  = 4,
    parameter int MAX_PULSES = 6,
    localparam int DEPTH     = NUM_SECT * SECT_WORDS,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int SECT_W    = $clog2(SECT_WORDS),
    localparam int PC_W      = $clog2(MAX_PULSES + 1),
    localparam int CYC_W     = $clog2(PULSE_CYC + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM_SECT-1:0] sector_sel,
    input  logic                abort,
    input  logic [DATA_W-1:0]   vf_data,
    output logic [ADDR_W-1:0]   vf_addr,
    output logic                pgm_en,
    output logic                pulse_en,
    output logic                scr_en,
    output logic [NUM_SECT-1:0] sel,
    output logic                busy,
    output logic                ers_phase,
    output logic                fail
);
    typedef struct packed {
        efs_state_e          state;
        logic [ADDR_W-1:0]   cursor;
        logic [PC_W-1:0]     pulses;
        logic [CYC_W-1:0]    cyc;
        logic [NUM_SECT-1:0] sel;
        logic                fail;
    } ctrl_t;

    ctrl_t r_d, r_q;
    logic  last, cur_sel;

    always_comb begin
        r_d      = r_q;
        pgm_en   = 1'b0;
        pulse_en = 1'b0;
        scr_en   = 1'b0;
        last     = (r_q.cursor == ADDR_W'(DEPTH - 1));
        cur_sel  = r_q.sel[r_q.cursor[ADDR_W-1:SECT_W]];
        if (abort && r_q.state != ST_IDLE) begin
            scr_en    = 1'b1;
            r_d.state = ST_IDLE;
        end else begin
            unique case (r_q.state)
                ST_IDLE: if (start) begin
                    r_d.sel    = sector_sel;
                    r_d.cursor = '0;
                    r_d.pulses = '0;
                    r_d.cyc    = '0;
                    r_d.fail   = 1'b0;
                    r_d.state  = ST_PRE_PGM;
                end
                ST_PRE_PGM: begin
                    pgm_en     = cur_sel;
                    r_d.cursor = r_q.cursor + 1'b1;
                    if (last) r_d.state = ST_PRE_VFY;
                end
                ST_PRE_VFY: begin
                    if (cur_sel && vf_data != '0) begin
                        r_d.cursor = '0;
                        r_d.state  = ST_PRE_PGM;
                    end else begin
                        r_d.cursor = r_q.cursor + 1'b1;
                        if (last) begin
                            r_d.cyc   = '0;
                            r_d.state = ST_ERS_PULSE;
                        end
                    end
                end
                ST_ERS_PULSE: begin
                    r_d.cyc = r_q.cyc + 1'b1;
                    if (r_q.cyc == CYC_W'(PULSE_CYC - 1)) begin
                        pulse_en   = 1'b1;
                        r_d.pulses = r_q.pulses + 1'b1;
                        r_d.cursor = '0;
                        r_d.state  = ST_ERS_VFY;
                    end
                end
                ST_ERS_VFY: begin
                    if (cur_sel && vf_data != '1) begin
                        r_d.cursor = '0;
                        r_d.cyc    = '0;
                        if (r_q.pulses == PC_W'(MAX_PULSES)) begin
                            r_d.fail  = 1'b1;
                            r_d.state = ST_IDLE;
                        end else begin
                            r_d.state = ST_ERS_PULSE;
                        end
                    end else begin
                        r_d.cursor = r_q.cursor + 1'b1;
                        if (last) r_d.state = ST_IDLE;
                    end
                end
                default: r_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{state: ST_IDLE, default: '0};
        else        r_q <= r_d;
    end

    assign vf_addr   = r_q.cursor;
    assign sel       = r_q.sel;
    assign busy      = (r_q.state != ST_IDLE);
    assign ers_phase = (r_q.state == ST_ERS_PULSE) || (r_q.state == ST_ERS_VFY);
    assign fail      = r_q.fail;

    // R8
    pulse_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.pulses <= PC_W'(MAX_PULSES));
    // R2
    sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state != ST_IDLE) |=> $stable(r_q.sel));
    // R3
    phase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_ERS_PULSE) |-> ($past(r_q.state) != ST_PRE_PGM && $past(r_q.state) != ST_IDLE));
endmodule

// File: rtl/efs_erase_engine.sv
module efs_erase_engine #(
    parameter int DATA_W     = 8,
    parameter int NUM_SECT   = 4,
    parameter int SECT_WORDS = 4,
    parameter int STEP       = 2,
    parameter int PULSE_CYC  = 4,
    parameter int MAX_PULSES = 6,
    localparam int DEPTH     = NUM_SECT * SECT_WORDS,
    localparam int ADDR_W    = $clog2(DEPTH),
    localparam int SECT_W    = $clog2(SECT_WORDS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [NUM_SECT-1:0] sector_sel,
    input  logic                abort,
    input  logic                ld_en,
    input  logic [ADDR_W-1:0]   ld_addr,
    input  logic [DATA_W-1:0]   ld_data,
    input  logic [ADDR_W-1:0]   rd_addr,
    output logic [DATA_W-1:0]   rd_data,
    output logic                busy_n,
    output logic                erase_fail
);
    logic [DATA_W-1:0]   arr_rd, vf_data;
    logic [ADDR_W-1:0]   vf_addr;
    logic                pgm_en, pulse_en, scr_en, busy, ers_phase, ld_ok;
    logic [NUM_SECT-1:0] sel;
    logic [7:0]          seed;
    logic [DATA_W-1:0]   status;

    efs_lfsr #(.W(8)) u_lfsr (.clk(clk), .rst_n(rst_n), .value(seed));

    efs_ctrl #(
        .DATA_W(DATA_W), .NUM_SECT(NUM_SECT), .SECT_WORDS(SECT_WORDS),
        .PULSE_CYC(PULSE_CYC), .MAX_PULSES(MAX_PULSES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_sel(sector_sel),
        .abort(abort), .vf_data(vf_data), .vf_addr(vf_addr), .pgm_en(pgm_en),
        .pulse_en(pulse_en), .scr_en(scr_en), .sel(sel), .busy(busy),
        .ers_phase(ers_phase), .fail(erase_fail)
    );

    assign ld_ok = ld_en && !busy;

    efs_array #(
        .DATA_W(DATA_W), .NUM_SECT(NUM_SECT), .SECT_WORDS(SECT_WORDS), .STEP(STEP)
    ) u_array (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_ok), .ld_addr(ld_addr),
        .ld_data(ld_data), .pgm_en(pgm_en), .pgm_addr(vf_addr),
        .pulse_en(pulse_en), .scr_en(scr_en), .sel(sel), .seed(seed),
        .rd_addr(rd_addr), .vf_addr(vf_addr), .rd_data(arr_rd), .vf_data(vf_data)
    );

    assign status  = DATA_W'(8) | (ers_phase ? DATA_W'(4) : DATA_W'(0));
    assign rd_data = (busy && sel[rd_addr[ADDR_W-1:SECT_W]]) ? status : arr_rd;
    assign busy_n  = !busy;

    // R7
    abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !busy_n) |=> busy_n);
    // R8
    fail_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_fail) |-> busy_n);
endmodule

// File: tb/tb_efs_erase_engine.sv
module tb_efs_erase_engine;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0, rst_n = 0;
    logic       start = 0, abort = 0, ld_en = 0;
    logic [3:0] sector_sel = 0, ld_addr = 0, rd_addr = 0;
    logic [7:0] ld_data = 0, rd_data;
    logic       busy_n, erase_fail;
    logic       l_start = 0;
    logic [3:0] l_sel = 0, l_rd = 0;
    logic [7:0] l_data;
    logic       l_busy_n, l_fail;

    int nchk = 0, nerr = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    efs_erase_engine dut (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_sel(sector_sel),
        .abort(abort), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy_n(busy_n), .erase_fail(erase_fail)
    );

    efs_erase_engine #(.MAX_PULSES(3)) dut_lim (
        .clk(clk), .rst_n(rst_n), .start(l_start), .sector_sel(l_sel),
        .abort(1'b0), .ld_en(1'b0), .ld_addr(4'd0), .ld_data(8'd0),
        .rd_addr(l_rd), .rd_data(l_data), .busy_n(l_busy_n), .erase_fail(l_fail)
    );

    // {mask, seed}
    localparam logic [11:0] VEC [6] = '{
        {4'b0001, 8'h3C}, {4'b1010, 8'h00}, {4'b1111, 8'hC3},
        {4'b0110, 8'hFF}, {4'b1000, 8'h5A}, {4'b0101, 8'h81}
    };

    function automatic logic [7:0] pat(input logic [7:0] s, input int a);
        return s ^ 8'(a * 29);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic rd(input int a, output logic [7:0] v);
        rd_addr = 4'(a);
        #1 v = rd_data;
    endtask

    task automatic load_all(input logic [7:0] s);
        for (int a = 0; a < 16; a++) begin
            @(negedge clk); ld_en = 1; ld_addr = 4'(a); ld_data = pat(s, a);
        end
        @(negedge clk); ld_en = 0;
    endtask

    task automatic kick(input logic [3:0] m);
        @(negedge clk); start = 1; sector_sel = m;
        @(negedge clk); start = 0;
    endtask

    // waits for busy_n; watches the status byte at mon
    task automatic wait_done(input int mon, output bit bad7, output bit bad_ord,
                             output bit seen_pre, output bit seen_ers);
        logic [7:0] v;
        bad7 = 0; bad_ord = 0; seen_pre = 0; seen_ers = 0;
        for (int c = 0; c < 3000; c++) begin
            rd(mon, v);
            if (busy_n) break;
            if (v[7] !== 1'b0 || v[3] !== 1'b1) bad7 = 1;
            if (v[2] === 1'b1) seen_ers = 1;
            else begin seen_pre = 1; if (seen_ers) bad_ord = 1; end
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            nerr++;
            $display("FAIL watchdog act=hung exp=done");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] s;
        logic [3:0] m;
        bit b7, bo, sp, se;
        int mon;

        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy_n", busy_n, 1);
        chk("R1 erase_fail", erase_fail, 0);
        for (int a = 0; a < 16; a += 5) begin rd(a, v); chk("R1 reset data", v, 8'hA5 ^ 8'(a)); end

        // vector table: R4, R6, R5, R3, R9
        for (int k = 0; k < 6; k++) begin
            m = VEC[k][11:8]; s = VEC[k][7:0];
            load_all(s);
            rd(7, v); chk("R9 idle load", v, pat(s, 7));
            mon = 0;
            for (int q = 3; q >= 0; q--) if (m[q]) mon = q * 4;
            kick(m);
            chk("R2 busy after start", busy_n, 0);
            wait_done(mon, b7, bo, sp, se);
            chk("R5 status bit7/bit3", b7, 0);
            chk("R3 phase order", {bo, sp, se}, 3'b011);
            chk("R4 fail clear", erase_fail, 0);
            for (int a = 0; a < 16; a++) begin
                rd(a, v);
                if (m[a / 4]) chk("R4 erased byte", v, 8'hFF);
                else          chk("R6 untouched byte", v, pat(s, a));
            end
        end

        // R5 any address in the sector; R6 unselected readable while busy; R2 late start; R9 load while busy
        load_all(8'h42);
        kick(4'b0010);
        for (int a = 4; a < 8; a++) begin
            rd(a, v); chk("R5 poll any addr", {v[7], v[3]}, 2'b01);
            @(negedge clk);
        end
        rd(0, v); chk("R6 read while busy", v, pat(8'h42, 0));
        start = 1; sector_sel = 4'b1111; ld_en = 1; ld_addr = 4'd1; ld_data = 8'h00;
        @(negedge clk); start = 0; ld_en = 0;
        wait_done(4, b7, bo, sp, se);
        rd(0, v);  chk("R2 late start ignored", v, pat(8'h42, 0));
        rd(1, v);  chk("R9 busy load dropped", v, pat(8'h42, 1));
        rd(12, v); chk("R2 late start ignored s3", v, pat(8'h42, 12));
        rd(5, v);  chk("R4 sector1 erased", v, 8'hFF);

        // R7 abort
        load_all(8'h17);
        kick(4'b0100);
        repeat (5) @(negedge clk);
        abort = 1;
        @(negedge clk); abort = 0;
        chk("R7 busy_n after abort", busy_n, 1);
        for (int a = 8; a < 12; a++) begin rd(a, v); chk("R7 scrambled bit7", v[7], 0); end
        rd(3, v);  chk("R7 other sector kept", v, pat(8'h17, 3));
        rd(13, v); chk("R7 other sector kept", v, pat(8'h17, 13));
        load_all(8'h60);
        abort = 1;
        @(negedge clk); abort = 0;
        rd(9, v); chk("R7 idle abort no effect", v, pat(8'h60, 9));
        chk("R7 idle abort busy_n", busy_n, 1);
        kick(4'b0100);
        wait_done(8, b7, bo, sp, se);
        for (int a = 8; a < 12; a++) begin rd(a, v); chk("R7 restart erased", v, 8'hFF); end

        // R10 empty mask
        load_all(8'h99);
        kick(4'b0000);
        wait_done(0, b7, bo, sp, se);
        for (int a = 0; a < 16; a += 3) begin rd(a, v); chk("R10 empty mask no change", v, pat(8'h99, a)); end
        chk("R10 done", busy_n, 1);

        // R8 pulse limit on the MAX_PULSES=3 instance
        @(negedge clk); l_start = 1; l_sel = 4'b0001;
        @(negedge clk); l_start = 0;
        chk("R8 limited busy", l_busy_n, 0);
        for (int c = 0; c < 3000 && !l_busy_n; c++) @(negedge clk);
        chk("R8 fail flag", l_fail, 1);
        chk("R8 ready after fail", l_busy_n, 1);
        for (int a = 0; a < 4; a++) begin l_rd = 4'(a); #1 chk("R8 partial byte", l_data, 8'h3F); end
        l_rd = 4'd6; #1 chk("R8 other sector kept", l_data, 8'hA5 ^ 8'd6);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
        $finish;
    end
endmodule